// File: doc/BRIEF.md
# Proxy-Addressed Remote Packet Header Builder

This block sits on the transmit side of a network interface. Software starts a send by naming a destination through a device-proxy address together with a byte count. The block never receives the destination node directly. It splits the proxy address into a page number and an offset within a 4 KiB page, and uses the low bits of the page number as a direct index into a page table. The selected entry supplies the destination node and the remote physical page. The remote physical address is that page joined with the untouched offset.

For each accepted request, the block emits one packet on a valid/ready output stream. The packet is a two-word header followed by the payload words, which come from the DMA engine's valid/ready stream and pass through without being stored. Back-pressure rules: a word moves only in a cycle where `out_valid` and `out_ready` are both high. While a header word is stalled, it is held unchanged. During the payload phase, `pay_ready` follows `out_ready`, so a stall on the output stalls the DMA source in the same cycle. A new request is accepted only when no packet is in progress, so two packets never mix.

Software fills the table through a plain write port. Each entry carries a valid bit, and all entries are invalid after reset. A request that selects an invalid entry, or that breaks the 4-byte alignment rule, is dropped and reported with a one-cycle error pulse.

Top module: `proxy_hdr_builder`

## Requirements
- R1: After reset, `req_ready`=1, `out_valid`=0, `pay_ready`=0 and both error pulses are 0. Every table entry is invalid, so the first request after reset to any index is dropped as unmapped.
- R2: The table index is the low IDX_W bits of the page number, `req_addr[OFF_W +: IDX_W]` (bits 21:12 by default). Page-number bits above the index do not affect the lookup.
- R3: Header word 0 carries the entry's node ID in bits 31:16 and the request byte count in bits 15:0.
- R4: Header word 1 is the remote address. It is the entry's page number in bits 31:12 followed by `req_addr[11:0]` in bits 11:0.
- R5: A packet is header word 0, header word 1, then exactly `req_len/4` payload words, with `out_last` high on the final word only. When `req_len`=0 the packet is header-only and `out_last` is set on header word 1.
- R6: The lookup takes one registered table read, and its result is registered before the header is sent. With the request accepted on edge A, `out_valid` stays low for the cycle after A and the first header word is presented after edge A+1.
- R7: A stalled header word keeps its data and `out_last` unchanged. `req_ready` stays low from acceptance until the edge that transfers the packet's last word, and is high again in the cycle after that edge.
- R8: A request whose entry is invalid produces no output words and consumes no payload. `err_unmapped` pulses high for one cycle, in the cycle after edge A+1, and the block is ready again in that cycle.
- R9: A request with `req_addr[1:0]`≠0 or `req_len[1:0]`≠0 is dropped without a lookup. `err_misalign` pulses high for one cycle, in the cycle after the accepting edge, and no words are produced.
- R10: `pay_ready` is high only during the payload phase and only when `out_ready` is high. In that phase `out_data` equals `pay_data`, and payload words appear in arrival order.
- R11: A table write with the valid bit set makes later lookups of that index return the written node and page. A write with the valid bit clear makes later lookups of that index unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | IDX_W | Table entry to write |
| tbl_valid | input | 1 | Valid bit written into the entry |
| tbl_node | input | NODE_W | Destination node ID written into the entry |
| tbl_page | input | ADDR_W-OFF_W | Remote physical page written into the entry |
| req_valid | input | 1 | Send request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Device-proxy destination address |
| req_len | input | LEN_W | Payload length in bytes |
| pay_valid | input | 1 | Payload word from the DMA engine present |
| pay_ready | output | 1 | Payload word taken this cycle |
| pay_data | input | WORD_W | Payload word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Output sink accepts the word |
| out_data | output | WORD_W | Header or payload word |
| out_last | output | 1 | Final word of the packet |
| err_unmapped | output | 1 | One-cycle pulse: request dropped on an invalid entry |
| err_misalign | output | 1 | One-cycle pulse: request dropped for breaking 4-byte alignment |

## Verification
Any sequencer state that is out of step shows at the ports within one or two cycles of a request. Examples are a packet that starts too early, a header that stays up after its handshake, or a payload counter that stops one word off. These show as a shifted first-valid cycle, a repeated or missing word, or a misplaced `out_last`. A table entry that is corrupted or read from the wrong index shows in header word 0 or header word 1 of the very next packet to that index. A stale valid bit turns an expected drop into a packet, or a packet into an `err_unmapped` pulse, two cycles after acceptance. Payload mishandling shows as a mismatch between the words leaving and the order in which the DMA source was drained.

// File: rtl/phb_pkg.sv
`timescale 1ns/1ps
package phb_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_HDR0,
    S_HDR1,
    S_PAY
  } phb_state_e;
endpackage

// File: rtl/phb_addr_split.sv
`timescale 1ns/1ps
module phb_addr_split #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int LEN_W  = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic [OFF_W-1:0]  offset,
  output logic [IDX_W-1:0]  index,
  output logic              aligned,
  output logic [LEN_W-3:0]  nwords
);
  // page number bits above the index take no part in the lookup
  logic unused_page_hi;
  assign unused_page_hi = ^addr[ADDR_W-1:OFF_W+IDX_W];

  assign offset  = addr[OFF_W-1:0];
  assign index   = addr[OFF_W +: IDX_W];
  assign aligned = (addr[1:0] == 2'b00) && (len[1:0] == 2'b00);
  assign nwords  = len[LEN_W-1:2];
endmodule

// File: rtl/phb_page_table.sv
`timescale 1ns/1ps
module phb_page_table #(
  parameter int IDX_W  = 10,
  parameter int NODE_W = 16,
  parameter int PPN_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [NODE_W-1:0] wr_node,
  input  logic [PPN_W-1:0]  wr_page,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_hit,
  output logic [NODE_W-1:0] rd_node,
  output logic [PPN_W-1:0]  rd_page
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = NODE_W + PPN_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] valid_q;

  // entry payload: no reset, plain synchronous memory
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_node, wr_page};
  end

  always_ff @(posedge clk) begin
    if (rd_en) {rd_node, rd_page} <= mem[rd_idx];
  end

  // valid bits cleared by reset so the table starts empty
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= wr_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hit <= 1'b0;
    end else if (rd_en) begin
      rd_hit <= valid_q[rd_idx];
    end
  end
endmodule

// File: rtl/phb_sequencer.sv
`timescale 1ns/1ps
module phb_sequencer
  import phb_pkg::*;
#(
  parameter int OFF_W  = 12,
  parameter int NODE_W = 16,
  parameter int PPN_W  = 20,
  parameter int LEN_W  = 16,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_aligned,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [LEN_W-3:0]  req_nwords,
  output logic              tbl_rd_en,
  input  logic              tbl_hit,
  input  logic [NODE_W-1:0] tbl_node,
  input  logic [PPN_W-1:0]  tbl_page,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic [WORD_W-1:0] pay_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic              err_unmapped,
  output logic              err_misalign,
  output logic              hdr_phase
);
  localparam int CNT_W = LEN_W - 2;

  phb_state_e        state_q;
  logic [OFF_W-1:0]  off_q;
  logic [LEN_W-1:0]  len_q;
  logic [CNT_W-1:0]  left_q;
  logic [NODE_W-1:0] node_q;
  logic [PPN_W-1:0]  page_q;
  logic              accept;
  logic              pay_move;

  assign req_ready = (state_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign tbl_rd_en = accept && req_aligned;
  assign pay_move  = (state_q == S_PAY) && pay_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      off_q        <= '0;
      len_q        <= '0;
      left_q       <= '0;
      node_q       <= '0;
      page_q       <= '0;
      err_unmapped <= 1'b0;
      err_misalign <= 1'b0;
    end else begin
      err_unmapped <= 1'b0;
      err_misalign <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (accept) begin
            if (req_aligned) begin
              off_q   <= req_off;
              len_q   <= req_len;
              left_q  <= req_nwords;
              state_q <= S_LOOK;
            end else begin
              err_misalign <= 1'b1;
            end
          end
        end
        S_LOOK: begin
          // table output is registered here before any header word leaves
          if (tbl_hit) begin
            node_q  <= tbl_node;
            page_q  <= tbl_page;
            state_q <= S_HDR0;
          end else begin
            err_unmapped <= 1'b1;
            state_q      <= S_IDLE;
          end
        end
        S_HDR0: begin
          if (out_ready) state_q <= S_HDR1;
        end
        S_HDR1: begin
          if (out_ready) state_q <= (left_q == '0) ? S_IDLE : S_PAY;
        end
        S_PAY: begin
          if (pay_move) begin
            left_q <= left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    out_last  = 1'b0;
    pay_ready = 1'b0;
    hdr_phase = 1'b0;
    case (state_q)
      S_HDR0: begin
        out_valid = 1'b1;
        out_data  = {node_q, len_q};
        hdr_phase = 1'b1;
      end
      S_HDR1: begin
        out_valid = 1'b1;
        out_data  = {page_q, off_q};
        out_last  = (left_q == '0);
        hdr_phase = 1'b1;
      end
      S_PAY: begin
        out_valid = pay_valid;
        out_data  = pay_data;
        out_last  = (left_q == CNT_W'(1));
        pay_ready = out_ready;
      end
      default: begin
        out_valid = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/proxy_hdr_builder.sv
`timescale 1ns/1ps
module proxy_hdr_builder #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int NODE_W = 16,
  parameter int LEN_W  = 16,
  parameter int WORD_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tbl_we,
  input  logic [IDX_W-1:0]        tbl_idx,
  input  logic                    tbl_valid,
  input  logic [NODE_W-1:0]       tbl_node,
  input  logic [ADDR_W-OFF_W-1:0] tbl_page,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LEN_W-1:0]        req_len,
  input  logic                    pay_valid,
  output logic                    pay_ready,
  input  logic [WORD_W-1:0]       pay_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [WORD_W-1:0]       out_data,
  output logic                    out_last,
  output logic                    err_unmapped,
  output logic                    err_misalign
);
  localparam int PPN_W = ADDR_W - OFF_W;

  logic [OFF_W-1:0]  sp_off;
  logic [IDX_W-1:0]  sp_idx;
  logic              sp_aligned;
  logic [LEN_W-3:0]  sp_nwords;
  logic              rd_en;
  logic              rd_hit;
  logic [NODE_W-1:0] rd_node;
  logic [PPN_W-1:0]  rd_page;
  logic              hdr_phase;

  phb_addr_split #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEN_W(LEN_W)
  ) split_i (
    .addr    (req_addr),
    .len     (req_len),
    .offset  (sp_off),
    .index   (sp_idx),
    .aligned (sp_aligned),
    .nwords  (sp_nwords)
  );

  phb_page_table #(
    .IDX_W(IDX_W), .NODE_W(NODE_W), .PPN_W(PPN_W)
  ) table_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_we),
    .wr_idx   (tbl_idx),
    .wr_valid (tbl_valid),
    .wr_node  (tbl_node),
    .wr_page  (tbl_page),
    .rd_en    (rd_en),
    .rd_idx   (sp_idx),
    .rd_hit   (rd_hit),
    .rd_node  (rd_node),
    .rd_page  (rd_page)
  );

  phb_sequencer #(
    .OFF_W(OFF_W), .NODE_W(NODE_W), .PPN_W(PPN_W), .LEN_W(LEN_W), .WORD_W(WORD_W)
  ) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_aligned  (sp_aligned),
    .req_off      (sp_off),
    .req_len      (req_len),
    .req_nwords   (sp_nwords),
    .tbl_rd_en    (rd_en),
    .tbl_hit      (rd_hit),
    .tbl_node     (rd_node),
    .tbl_page     (rd_page),
    .pay_valid    (pay_valid),
    .pay_ready    (pay_ready),
    .pay_data     (pay_data),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_last     (out_last),
    .err_unmapped (err_unmapped),
    .err_misalign (err_misalign),
    .hdr_phase    (hdr_phase)
  );
endmodule

// File: rtl/phb_checker.sv
`timescale 1ns/1ps
module phb_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              pay_valid,
  input logic              pay_ready,
  input logic [WORD_W-1:0] pay_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              out_last,
  input logic              err_unmapped,
  input logic              err_misalign,
  input logic              hdr_phase
);
  p_hdr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && hdr_phase) |=>
      (out_valid && $stable(out_data) && $stable(out_last)));

  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);

  p_pay_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready |-> (out_ready && !hdr_phase));

  p_pay_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_ready && pay_valid) |-> (out_valid && out_data == pay_data));

  p_lookup_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !out_valid);

  p_drop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_unmapped |-> (!out_valid && req_ready));

  p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_unmapped, err_misalign}));
endmodule

bind proxy_hdr_builder phb_checker #(.WORD_W(WORD_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .pay_valid    (pay_valid),
  .pay_ready    (pay_ready),
  .pay_data     (pay_data),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .out_last     (out_last),
  .err_unmapped (err_unmapped),
  .err_misalign (err_misalign),
  .hdr_phase    (hdr_phase)
);

// File: tb/proxy_hdr_builder_tb_top.sv
`timescale 1ns/1ps
module proxy_hdr_builder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 10;
  localparam int DEPTH = 1 << IDX_W;

  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] len;
    logic        stall;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_5100, 16'd16, 1'b0},  // R3 R4 R5 basic
    '{32'h0000_9FFC, 16'd4,  1'b1},  // R4 top offset, stalls
    '{32'h7FC0_5040, 16'd12, 1'b1},  // R2 aliases index 5
    '{32'h003F_F000, 16'd0,  1'b0},  // R5 header only, last index
    '{32'h0000_0200, 16'd8,  1'b0},  // R8 invalid entry
    '{32'h0000_5102, 16'd8,  1'b0},  // R9 misaligned address
    '{32'h0000_5100, 16'd6,  1'b0},  // R9 misaligned length
    '{32'h0000_9000, 16'd32, 1'b1}   // R10 long payload, stalls
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [9:0]  tbl_idx = '0;
  logic        tbl_valid = 1'b0;
  logic [15:0] tbl_node = '0;
  logic [19:0] tbl_page = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic        pay_valid = 1'b1;
  logic        pay_ready;
  logic [31:0] pay_data;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_last;
  logic        err_unmapped;
  logic        err_misalign;

  logic [31:0] pay_cnt;
  int n_chk = 0;
  int n_fail = 0;

  logic        m_v    [DEPTH];
  logic [15:0] m_node [DEPTH];
  logic [19:0] m_page [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  // DMA source model: word value advances on every taken word
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) pay_cnt <= '0;
    else if (pay_valid && pay_ready) pay_cnt <= pay_cnt + 32'd1;
  end
  assign pay_data = 32'hD000_0000 + pay_cnt;

  proxy_hdr_builder dut_i (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_valid(tbl_valid),
    .tbl_node(tbl_node), .tbl_page(tbl_page),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last),
    .err_unmapped(err_unmapped), .err_misalign(err_misalign)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    clear_model();
    @(negedge clk);
  endtask

  task automatic wr_entry(input int idx, input bit v, input logic [15:0] nd, input logic [19:0] pg);
    tbl_we = 1'b1; tbl_idx = 10'(idx); tbl_valid = v; tbl_node = nd; tbl_page = pg;
    @(negedge clk);
    tbl_we = 1'b0;
    m_v[idx] = v; m_node[idx] = nd; m_page[idx] = pg;
  endtask

  task automatic run_pkt(input logic [31:0] a, input logic [15:0] l, input bit stall);
    int idx, nw, exp_cnt, got, first_v, pay_base;
    bit misal, done, saw_um, saw_ma, held_v;
    logic [31:0] held, expw;
    idx = int'(a[21:12]);
    misal = (a[1:0] != 2'b00) || (l[1:0] != 2'b00);
    nw = int'(l >> 2);
    exp_cnt = (misal || !m_v[idx]) ? 0 : nw + 2;
    got = 0; first_v = -1; done = 0; saw_um = 0; saw_ma = 0; held_v = 0; held = '0;
    pay_base = int'(pay_cnt);
    chk(req_ready == 1'b1, "R7 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_addr = a; req_len = l;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 400 && !done; c++) begin
      out_ready = stall ? (c % 3 != 1) : 1'b1;
      #1;
      if (err_unmapped) saw_um = 1;
      if (err_misalign) saw_ma = 1;
      if (c == 0 && err_misalign != misal) chk(0, "R9 pulse cycle", 32'(err_misalign), 32'(misal));
      if (out_valid && first_v < 0) first_v = c;
      if (pay_ready) chk(out_ready && got >= 2, "R10 pay_ready gating", 32'(got), 32'd2);
      if (held_v && got < 2) chk(out_data == held, "R7 header held", out_data, held);
      held_v = out_valid && !out_ready && got < 2;
      held = out_data;
      if (out_valid) chk(!req_ready, "R7 no request during packet", 32'(req_ready), 32'd0);
      if (out_valid && out_ready) begin
        if (got == 0)      expw = {m_node[idx], l};
        else if (got == 1) expw = {m_page[idx], a[11:0]};
        else               expw = 32'hD000_0000 + 32'(pay_base + got - 2);
        chk(out_data == expw, (got == 0) ? "R3 header word 0" : (got == 1) ? "R4 header word 1" : "R10 payload word", out_data, expw);
        chk(out_last == (got == exp_cnt - 1), "R5 last flag", 32'(out_last), 32'(got == exp_cnt - 1));
        got++;
        if (out_last) done = 1;
      end
      if (exp_cnt == 0 && c >= 3) done = 1;
      @(negedge clk);
    end
    out_ready = 1'b1;
    chk(got == exp_cnt, "R5 word count", 32'(got), 32'(exp_cnt));
    if (exp_cnt > 0) chk(first_v == 1, "R6 header latency", 32'(first_v), 32'd1);
    chk(saw_ma == misal, "R9 misalign pulse", 32'(saw_ma), 32'(misal));
    chk(saw_um == (!misal && !m_v[idx]), "R8 unmapped pulse", 32'(saw_um), 32'(!misal && !m_v[idx]));
    chk(int'(pay_cnt) - pay_base == ((exp_cnt > 0) ? nw : 0), "R8 R10 payload words consumed",
        32'(int'(pay_cnt) - pay_base), 32'((exp_cnt > 0) ? nw : 0));
    chk(req_ready == 1'b1, "R7 ready after packet", 32'(req_ready), 32'd1);
  endtask

  initial begin
    clear_model();
    do_reset();
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
    chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
    chk(pay_ready == 1'b0, "R1 pay_ready", 32'(pay_ready), 32'd0);
    chk(!err_unmapped && !err_misalign, "R1 error pulses", {30'd0, err_unmapped, err_misalign}, 32'd0);
    run_pkt(32'h0000_5100, 16'd8, 1'b0);   // R1 table empty -> unmapped

    wr_entry(5,    1'b1, 16'h0A01, 20'hABCDE);
    wr_entry(9,    1'b1, 16'h0B02, 20'h12345);
    wr_entry(1023, 1'b1, 16'hFFFE, 20'h00001);
    wr_entry(0,    1'b0, 16'h1111, 20'h22222);

    for (int i = 0; i < NV; i++) run_pkt(VECS[i].addr, VECS[i].len, VECS[i].stall);

    // R11 rewrite then invalidate an entry
    wr_entry(9, 1'b1, 16'h0C03, 20'hFEDCB);
    run_pkt(32'h0000_9010, 16'd8, 1'b0);
    wr_entry(9, 1'b0, 16'h0C03, 20'hFEDCB);
    run_pkt(32'h0000_9010, 16'd8, 1'b0);

    // R1 reset clears a populated table
    do_reset();
    run_pkt(32'h0000_5100, 16'd4, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired R5: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule